// File: doc/BRIEF.md
# UTOPIA Transmit Cell Ingress

This block takes ATM cells from a layer processor over a single-PHY UTOPIA-style transmit bus and stores them, one byte per location, in an internal cell FIFO. A downstream consumer reads that FIFO one byte at a time. The sender writes by pulling an active-low enable low. A start-of-cell flag on the first beat frames each cell. After that flag the block takes in exactly one cell of the configured length. A configuration pin selects an 8-bit or a 16-bit bus, and a 2-bit code selects a cell length of 52, 53 or 54 bytes.

A cell only becomes visible to the reader once all of its bytes have arrived. A cell that another start-of-cell flag cuts short is thrown away. Its partial bytes are removed by moving the write position back to the last committed cell boundary. Every accepted beat is checked for odd parity, and a mismatch is recorded in a sticky flag. The cell-available output tells the sender whether a whole cell of the current size still fits.

Top module: `cell_ingress_tx`

## Requirements
- R1: After reset the FIFO is empty (`rd_nempty` low), `par_err` is low and `cell_avail` is high.
- R2: A beat is a rising clock edge with `tx_en_n` low. Nothing is sampled while `tx_en_n` is high. In 8-bit mode (`cfg_wide`=0) each beat stores one byte, taken from `tx_data[7:0]`. The bytes of a cell reach the reader in arrival order, and only after the beat that completes the cell.
- R3: `cfg_size` selects the cell length: 00 gives 52 bytes, 01 gives 53, 10 gives 54 and 11 gives 53.
- R4: In 16-bit mode (`cfg_wide`=1) each beat stores `tx_data[15:8]` first and then `tx_data[7:0]`. On the last beat of a 53-byte cell only `tx_data[15:8]` is stored, and the low byte is dropped.
- R5: Beats without `tx_soc` are ignored in two cases: before the first start-of-cell beat after reset, and after a cell has completed. They stay ignored until the next beat with `tx_soc` high.
- R6: A beat with `tx_soc` high that arrives before the current cell is complete discards every byte of that partial cell. The new cell then starts with this beat's data.
- R7: An accepted beat has correct parity when `tx_par` together with the active data lanes (8 bits, or 16 bits in wide mode) holds an odd number of ones. A mismatch sets `par_err`, which stays high until reset, and the beat's data is still stored.
- R8: `cell_avail` is high exactly when the free space left beyond the committed bytes is at least one configured cell length. A start-of-cell beat that arrives while `cell_avail` is low drops that whole cell.
- R9: `rd_data` shows the oldest committed byte while `rd_nempty` is high. A clock edge with `rd_en` high and `rd_nempty` high removes that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and core clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wide | input | 1 | 1 selects the 16-bit bus, 0 selects the 8-bit bus |
| cfg_size | input | 2 | Cell length code |
| tx_en_n | input | 1 | Active-low write enable |
| tx_soc | input | 1 | Start-of-cell flag, valid on a beat |
| tx_data | input | 16 | Cell data |
| tx_par | input | 1 | Odd-parity bit over the active lanes |
| cell_avail | output | 1 | Room for one whole cell |
| par_err | output | 1 | Sticky parity-mismatch flag |
| rd_en | input | 1 | Pop the oldest committed byte |
| rd_data | output | 8 | Oldest committed byte |
| rd_nempty | output | 1 | At least one committed byte is present |

## Verification
A wrong byte count or a wrong lane choice shows up as a wrong value on `rd_data`, or as a byte-count mismatch, on the first read after the affected cell commits. If the lockout or the runt rollback fails, extra or stale bytes appear in the read stream as soon as the next cell is drained. A bad fill computation changes `cell_avail` on the very next clock, before any read takes place. The reference model compares every output on every clock, so a divergence is reported within one cycle of becoming visible.

// File: rtl/cell_ingress_pkg.sv
package cell_ingress_pkg;
    localparam int LEN_W = 6;

    // cell length for a size code; 11 behaves like 01
    function automatic logic [LEN_W-1:0] cell_len(input logic [1:0] code);
        logic [LEN_W-1:0] n;
        case (code)
            2'b00:   n = LEN_W'(52);
            2'b10:   n = LEN_W'(54);
            default: n = LEN_W'(53);
        endcase
        return n;
    endfunction
endpackage

// File: rtl/byte_store.sv
module byte_store #(
    parameter int DEPTH = 128,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we0,
    input  logic [AW-1:0] wa0,
    input  logic [7:0]    wd0,
    input  logic          we1,
    input  logic [AW-1:0] wa1,
    input  logic [7:0]    wd1,
    input  logic [AW-1:0] ra,
    output logic [7:0]    rd
);
    logic [7:0] mem_q [DEPTH];

    // two byte lanes; the controller never gives both the same address
    always_ff @(posedge clk) begin
        if (we0) mem_q[wa0] <= wd0;
        if (we1) mem_q[wa1] <= wd1;
    end

    assign rd = mem_q[ra];
endmodule

// File: rtl/ingress_ctrl.sv
module ingress_ctrl
    import cell_ingress_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wide,
    input  logic [1:0]    cfg_size,
    input  logic          tx_en_n,
    input  logic          tx_soc,
    input  logic [15:0]   tx_data,
    input  logic          tx_par,
    input  logic          rd_en,
    output logic          we0,
    output logic [AW-1:0] wa0,
    output logic [7:0]    wd0,
    output logic          we1,
    output logic [AW-1:0] wa1,
    output logic [7:0]    wd1,
    output logic [AW-1:0] ra,
    output logic          cell_avail,
    output logic          par_err,
    output logic          rd_nempty,
    output logic          dbg_active,
    output logic [PW-1:0] dbg_wptr,
    output logic [PW-1:0] dbg_cptr,
    output logic [PW-1:0] dbg_rptr
);
    typedef struct packed {
        logic             active;
        logic [LEN_W-1:0] cnt;
        logic [PW-1:0]    wptr;
        logic [PW-1:0]    cptr;
        logic [PW-1:0]    rptr;
        logic             perr;
    } st_t;

    st_t st_d, st_q;

    logic [LEN_W-1:0] len, cnt0, remain, nb_c, cnt_n;
    logic [PW-1:0]    fill, free, base, nb_p;
    logic             beat, room, start, cont, take, two, odd_ok;

    always_comb begin
        st_d   = st_q;
        len    = cell_len(cfg_size);
        fill   = st_q.cptr - st_q.rptr;
        free   = PW'(DEPTH) - fill;
        room   = int'(free) >= int'(len);
        beat   = !tx_en_n;
        start  = beat && tx_soc && room;
        cont   = beat && !tx_soc && st_q.active;
        take   = start || cont;
        base   = start ? st_q.cptr : st_q.wptr;
        cnt0   = start ? '0 : st_q.cnt;
        remain = len - cnt0;
        two    = cfg_wide && (remain >= LEN_W'(2));
        nb_c   = two ? LEN_W'(2) : LEN_W'(1);
        nb_p   = two ? PW'(2) : PW'(1);
        cnt_n  = cnt0 + nb_c;
        odd_ok = cfg_wide ? ^{tx_data, tx_par} : ^{tx_data[7:0], tx_par};

        we0 = take;
        we1 = take && two;
        wa0 = base[AW-1:0];
        wa1 = AW'(base + PW'(1));
        wd0 = cfg_wide ? tx_data[15:8] : tx_data[7:0];
        wd1 = tx_data[7:0];

        // any start-of-cell beat first rolls back an unfinished cell
        if (beat && tx_soc) begin
            st_d.active = 1'b0;
            st_d.wptr   = st_q.cptr;
            st_d.cnt    = '0;
        end
        if (take) begin
            st_d.wptr   = base + nb_p;
            st_d.cnt    = cnt_n;
            st_d.active = 1'b1;
            if (cnt_n == len) begin
                st_d.active = 1'b0;
                st_d.cnt    = '0;
                st_d.cptr   = base + nb_p;
            end
            if (!odd_ok) st_d.perr = 1'b1;
        end
        if (rd_en && (st_q.cptr != st_q.rptr)) st_d.rptr = st_q.rptr + PW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ra         = st_q.rptr[AW-1:0];
    assign cell_avail = room;
    assign par_err    = st_q.perr;
    assign rd_nempty  = st_q.cptr != st_q.rptr;
    assign dbg_active = st_q.active;
    assign dbg_wptr   = st_q.wptr;
    assign dbg_cptr   = st_q.cptr;
    assign dbg_rptr   = st_q.rptr;
endmodule

// File: rtl/cell_ingress_tx.sv
module cell_ingress_tx #(
    parameter int DEPTH = 128,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wide,
    input  logic [1:0]  cfg_size,
    input  logic        tx_en_n,
    input  logic        tx_soc,
    input  logic [15:0] tx_data,
    input  logic        tx_par,
    output logic        cell_avail,
    output logic        par_err,
    input  logic        rd_en,
    output logic [7:0]  rd_data,
    output logic        rd_nempty
);
    logic          we0, we1;
    logic [AW-1:0] wa0, wa1, ra;
    logic [7:0]    wd0, wd1;
    logic          dbg_active;
    logic [PW-1:0] dbg_wptr, dbg_cptr, dbg_rptr;

    ingress_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_size(cfg_size),
        .tx_en_n(tx_en_n), .tx_soc(tx_soc), .tx_data(tx_data), .tx_par(tx_par),
        .rd_en(rd_en), .we0(we0), .wa0(wa0), .wd0(wd0), .we1(we1), .wa1(wa1),
        .wd1(wd1), .ra(ra), .cell_avail(cell_avail), .par_err(par_err),
        .rd_nempty(rd_nempty), .dbg_active(dbg_active), .dbg_wptr(dbg_wptr),
        .dbg_cptr(dbg_cptr), .dbg_rptr(dbg_rptr)
    );

    byte_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .we0(we0), .wa0(wa0), .wd0(wd0), .we1(we1), .wa1(wa1),
        .wd1(wd1), .ra(ra), .rd(rd_data)
    );
endmodule

// File: rtl/ingress_chk.sv
module ingress_chk
    import cell_ingress_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    cfg_size,
    input logic          tx_en_n,
    input logic          tx_soc,
    input logic          rd_en,
    input logic          rd_nempty,
    input logic          cell_avail,
    input logic          par_err,
    input logic          active,
    input logic [PW-1:0] wptr,
    input logic [PW-1:0] cptr,
    input logic [PW-1:0] rptr
);
    logic [PW-1:0] fill_c;
    assign fill_c = cptr - rptr;

    p_perr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |=> par_err);

    p_locked_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && (tx_en_n || !tx_soc)) |=> $stable(wptr));

    p_commit_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cptr != $past(cptr)) |->
        (int'(PW'(cptr - $past(cptr))) == int'(cell_len($past(cfg_size)))));

    p_fill_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fill_c) <= DEPTH);

    p_avail_room_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cell_avail |-> (DEPTH - int'(fill_c)) >= int'(cell_len(cfg_size)));

    p_pop_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_nempty) |=> (rptr == $past(rptr) + PW'(1)));
endmodule

bind cell_ingress_tx ingress_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .tx_en_n(tx_en_n),
    .tx_soc(tx_soc), .rd_en(rd_en), .rd_nempty(rd_nempty),
    .cell_avail(cell_avail), .par_err(par_err), .active(dbg_active),
    .wptr(dbg_wptr), .cptr(dbg_cptr), .rptr(dbg_rptr)
);

// File: tb/test_cell_ingress_tx.sv
`timescale 1ns/1ps
module test_cell_ingress_tx;
    localparam int DEPTH = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wide = 1'b0;
    logic [1:0]  cfg_size = 2'b00;
    logic        tx_en_n = 1'b1;
    logic        tx_soc = 1'b0;
    logic [15:0] tx_data = '0;
    logic        tx_par = 1'b0;
    logic        rd_en = 1'b0;
    logic        cell_avail, par_err, rd_nempty;
    logic [7:0]  rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cell_ingress_tx #(.DEPTH(DEPTH)) i_cell_ingress_tx (
        .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_size(cfg_size),
        .tx_en_n(tx_en_n), .tx_soc(tx_soc), .tx_data(tx_data), .tx_par(tx_par),
        .cell_avail(cell_avail), .par_err(par_err), .rd_en(rd_en),
        .rd_data(rd_data), .rd_nempty(rd_nempty)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int size_bytes(input logic [1:0] c);
        if (c == 2'b00) return 52;
        if (c == 2'b10) return 54;
        return 53;
    endfunction

    // ---------------- reference model ----------------
    byte unsigned done_q[$];
    byte unsigned part_q[$];
    bit  m_open = 0;
    bit  m_perr = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            done_q.delete(); part_q.delete(); m_open = 0; m_perr = 0;
        end else begin
            int want;
            bit accept;
            want = size_bytes(cfg_size);
            accept = 0;
            if (!tx_en_n) begin
                if (tx_soc) begin
                    part_q.delete();
                    m_open = (DEPTH - done_q.size()) >= want;
                    accept = m_open;
                end else begin
                    accept = m_open;
                end
            end
            if (rd_en && done_q.size() > 0) void'(done_q.pop_front());
            if (accept) begin
                int ones;
                ones = tx_par;
                if (cfg_wide) begin
                    part_q.push_back(tx_data[15:8]);
                    if (part_q.size() < want) part_q.push_back(tx_data[7:0]);
                    for (int i = 0; i < 16; i++) ones += tx_data[i];
                end else begin
                    part_q.push_back(tx_data[7:0]);
                    for (int i = 0; i < 8; i++) ones += tx_data[i];
                end
                if (ones % 2 == 0) m_perr = 1;
                if (part_q.size() == want) begin
                    foreach (part_q[k]) done_q.push_back(part_q[k]);
                    part_q.delete();
                    m_open = 0;
                end
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(rd_nempty == (done_q.size() > 0), "R9 rd_nempty", rd_nempty, done_q.size() > 0);
            if (done_q.size() > 0)
                chk(rd_data == done_q[0], "R2 rd_data order", rd_data, done_q[0]);
            chk(par_err == m_perr, "R7 par_err", par_err, m_perr);
            chk(cell_avail == ((DEPTH - done_q.size()) >= size_bytes(cfg_size)),
                "R8 cell_avail", cell_avail, (DEPTH - done_q.size()) >= size_bytes(cfg_size));
        end
    end

    // ---------------- stimulus ----------------
    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic beat(input bit soc, input logic [15:0] d, input bit good);
        logic x;
        x = cfg_wide ? ^d : ^d[7:0];
        tx_en_n = 1'b0; tx_soc = soc; tx_data = d; tx_par = good ? ~x : x;
        step();
        tx_en_n = 1'b1; tx_soc = 1'b0; tx_data = 16'hdead;
    endtask

    // send nbytes starting at seed; gap inserts an idle cycle with junk data
    task automatic send(input int nbytes, input int seed, input bit with_soc, input bit gap, input int bad_at);
        int words;
        words = cfg_wide ? (nbytes + 1) / 2 : nbytes;
        for (int w = 0; w < words; w++) begin
            logic [15:0] d;
            if (cfg_wide) d = {8'(seed + 2*w), 8'(seed + 2*w + 1)};
            else          d = {8'h5a, 8'(seed + w)};
            beat(with_soc && w == 0, d, w != bad_at);
            if (gap && (w % 5 == 2)) begin
                tx_data = 16'hbeef; step();
            end
        end
    endtask

    task automatic drain(output int n);
        n = 0;
        forever begin
            if (!rd_nempty) break;
            rd_en = 1'b1; n++;
            step();
        end
        rd_en = 1'b0;
        step();
    endtask

    initial begin
        int n;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk(rd_nempty == 1'b0, "R1 empty after reset", rd_nempty, 0);
        chk(par_err == 1'b0, "R1 par_err after reset", par_err, 0);
        chk(cell_avail == 1'b1, "R1 cell_avail after reset", cell_avail, 1);

        // R5: beats before any start-of-cell are ignored
        send(6, 8'h10, 0, 0, -1);
        step();
        chk(rd_nempty == 1'b0, "R5 pre-soc beats ignored", rd_nempty, 0);

        // R2/R3: 8-bit, 52-byte cell with idle gaps
        cfg_size = 2'b00;
        send(52, 8'h20, 1, 1, -1);
        chk(rd_nempty == 1'b1, "R2 cell visible after last beat", rd_nempty, 1);
        drain(n);
        chk(n == 52, "R3 52-byte cell count", n, 52);

        // R5: extra beats after a full cell are locked out
        cfg_size = 2'b10;
        send(60, 8'h40, 1, 0, -1);
        drain(n);
        chk(n == 54, "R5 lockout after full cell", n, 54);

        // R6: runt followed by a new start-of-cell
        cfg_size = 2'b01;
        send(20, 8'h60, 1, 0, -1);
        chk(rd_nempty == 1'b0, "R6 partial cell not visible", rd_nempty, 0);
        send(53, 8'h80, 1, 0, -1);
        drain(n);
        chk(n == 53, "R6 runt discarded", n, 53);

        // R4: 16-bit, 53-byte cell with dropped pad byte
        cfg_wide = 1'b1;
        cfg_size = 2'b01;
        send(54, 8'ha0, 1, 1, -1);
        drain(n);
        chk(n == 53, "R4 16-bit 53-byte cell", n, 53);

        // R3: code 11 behaves as 53 in 16-bit mode
        cfg_size = 2'b11;
        send(54, 8'h07, 1, 0, -1);
        drain(n);
        chk(n == 53, "R3 code 11 gives 53", n, 53);

        // R4: 16-bit 54-byte cell
        cfg_size = 2'b10;
        send(54, 8'hc3, 1, 0, -1);
        drain(n);
        chk(n == 54, "R4 16-bit 54-byte cell", n, 54);

        // R7: a bad-parity beat is kept and raises the sticky flag
        cfg_wide = 1'b0;
        cfg_size = 2'b00;
        send(52, 8'h33, 1, 0, 7);
        chk(par_err == 1'b1, "R7 parity error raised", par_err, 1);
        drain(n);
        chk(n == 52, "R7 bad-parity data kept", n, 52);
        send(52, 8'h44, 1, 0, -1);
        drain(n);
        chk(par_err == 1'b1, "R7 par_err sticky", par_err, 1);

        // R8: fill until no cell fits, then a start-of-cell is dropped
        cfg_wide = 1'b1;
        cfg_size = 2'b10;
        send(54, 8'h11, 1, 0, -1);
        send(54, 8'h22, 1, 0, -1);
        step();
        chk(cell_avail == 1'b0, "R8 cell_avail low when full", cell_avail, 0);
        send(54, 8'h33, 1, 0, -1);
        drain(n);
        chk(n == 108, "R8 cell dropped without room", n, 108);
        chk(cell_avail == 1'b1, "R8 cell_avail back after drain", cell_avail, 1);

        repeat (4) step();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule